// File: doc/BRIEF.md
# Pixel-Strip Stub Finder

This block searches every bunch crossing for track stubs in a two-layer tracker module. Each clock it takes a full frame of binary hits from a pixelated layer (16 rows by 120 columns) and from a strip layer (120 channels). In every pixel row and in the strip layer it joins neighbouring hits into clusters. It discards clusters that are too wide and encodes each surviving cluster as a centroid at half-pixel resolution. The number of centroids kept is capped per row and in the strip layer, and a flag is raised when a cap is exceeded.

Each strip centroid is moved by a signed phi offset. Every kept pixel centroid, in every row, is then compared against the shifted strip centroids. A pixel centroid that lies within a programmable window of one of them becomes a stub. The stub carries its row (the Z coordinate), the pixel centroid (phi) and the signed bend between the two layers. Results come out of a fixed three-register pipeline, and a new frame and a new configuration are accepted on every clock.

Top module: `stub_finder`

## Requirements
- R1: A cluster is a maximal run of adjacent set hits within one pixel row or within the strip layer. Its centroid code is the sum of its first and last column indices, giving a range of 0 to 238.
- R2: A cluster whose width in hits is greater than `wide_max` is discarded. It produces no centroid and does not count toward any cap. With `wide_max` = 0, every cluster is discarded.
- R3: In each pixel row, clusters are taken from the lowest column upward and the first 4 surviving ones are kept. A fifth surviving cluster in that row sets bit r of `row_ovf`, where bit r belongs to row r.
- R4: In the strip layer, the first 8 surviving clusters, counted from the lowest column, are kept. A ninth one sets `strip_ovf`.
- R5: Before comparison, each strip centroid has the two's-complement value of `phi_shift` added to it.
- R6: A pixel centroid P matches a shifted strip centroid S when |P − S| ≤ `win`. The bend P − S is reported as a 5-bit two's-complement value.
- R7: Each kept pixel centroid k (0..3) of row r is matched on its own in slot s = 4·r + k, so one strip centroid can form stubs in many rows. When several strip centroids qualify, the one kept earliest (lowest column) is used. A stub sets `stub_valid[s]` and puts `stub_word[17·s +: 17]` = {row[3:0], pixel centroid[7:0], bend[4:0]}. A slot with no stub holds an all-zero word.
- R8: Hits and configuration that are present at a rising edge n appear on the outputs after rising edge n+2. A new frame with its own configuration may be applied at every edge.
- R9: While `rst` is high at a rising edge, after that edge all stub outputs and both overflow outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bunch crossing per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pix_hits | input | 1920 | Pixel hits; row r, column c at bit r·120 + c |
| strip_hits | input | 120 | Strip hits; column c at bit c |
| phi_shift | input | 8 | Signed offset added to strip centroids, in half-pixels |
| win | input | 4 | Match window, in half-pixels |
| wide_max | input | 3 | Largest cluster width that is kept |
| stub_valid | output | 64 | One bit per stub slot |
| stub_word | output | 1088 | 17-bit stub word per slot |
| row_ovf | output | 16 | Per-row pixel centroid overflow |
| strip_ovf | output | 1 | Strip centroid overflow |

## Verification
The bench aims at clusters exactly at and one past the width limit. A design with an off-by-one there keeps or drops the wrong cluster and its stub. It fills rows and the strip layer past their caps to show that the lowest-column clusters are the ones kept and the flags rise. A wrong scan order shows up as stubs built on dropped centroids. Window edges at ±`win` and ±(`win`+1) and negative phi offsets catch a mishandled sign or comparison. A pair of strip centroids that both fit one pixel centroid exposes a design that picks the wrong one, and back-to-back frames with changing configuration catch a configuration that is not carried down the pipeline with its frame.

// File: rtl/stub_pkg.sv
package stub_pkg;
    localparam int CENT_W  = 8;   // centroid code width (half-pixel units)
    localparam int BEND_W  = 5;   // signed bend width
    localparam int ROW_W   = 4;   // row index width
    localparam int WIN_W   = 4;   // window width
    localparam int WIDE_W  = 3;   // wide-cluster limit width
    localparam int SHIFT_W = 8;   // signed phi offset width
    localparam int STUB_W  = ROW_W + CENT_W + BEND_W;

    typedef struct packed {
        logic [ROW_W-1:0]         row;
        logic [CENT_W-1:0]        phi;
        logic signed [BEND_W-1:0] bend;
    } stub_t;

    function automatic logic bend_in_window(logic signed [BEND_W-1:0] b,
                                            logic [WIN_W-1:0] w);
        return (int'(b) <= int'(w)) && (int'(b) >= -int'(w));
    endfunction
endpackage

// File: rtl/stub_cluster_enc.sv
module stub_cluster_enc
    import stub_pkg::*;
#(
    parameter int N    = 120,
    parameter int MAXC = 4
) (
    input  logic [N-1:0]                   hits,
    input  logic [WIDE_W-1:0]              wide_max,
    output logic [MAXC-1:0][CENT_W-1:0]    cent,
    output logic [MAXC-1:0]                vld,
    output logic                           ovf
);
    // zero padding on both sides marks cluster edges at the boundaries
    logic [N+1:0] ext;
    assign ext = {1'b0, hits, 1'b0};

    always_comb begin
        int first;
        int cnt;
        int width;
        cent  = '0;
        vld   = '0;
        ovf   = 1'b0;
        first = 0;
        cnt   = 0;
        width = 0;
        for (int i = 0; i < N; i++) begin
            if (ext[i+1] && !ext[i]) first = i;
            if (ext[i+1] && !ext[i+2]) begin
                width = i - first + 1;
                if (width <= int'(wide_max)) begin
                    if (cnt < MAXC) begin
                        for (int k = 0; k < MAXC; k++) begin
                            if (k == cnt) begin
                                cent[k] = CENT_W'(first + i);
                                vld[k]  = 1'b1;
                            end
                        end
                    end else begin
                        ovf = 1'b1;
                    end
                    cnt = cnt + 1;
                end
            end
        end
    end
endmodule

// File: rtl/stub_match.sv
module stub_match
    import stub_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int PMAX = 4,
    parameter int SMAX = 8,
    localparam int SLOTS = ROWS * PMAX
) (
    input  logic [ROWS-1:0][PMAX-1:0][CENT_W-1:0] pc,
    input  logic [ROWS-1:0][PMAX-1:0]             pv,
    input  logic [SMAX-1:0][CENT_W-1:0]           sc,
    input  logic [SMAX-1:0]                       sv,
    input  logic signed [SHIFT_W-1:0]             sh,
    input  logic [WIN_W-1:0]                      win,
    output logic [SLOTS-1:0]                      st_v,
    output stub_t [SLOTS-1:0]                     st
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int R = s / PMAX;
        localparam int K = s % PMAX;
        always_comb begin
            int d;
            st_v[s] = 1'b0;
            st[s]   = '0;
            d       = 0;
            for (int j = 0; j < SMAX; j++) begin
                d = int'(pc[R][K]) - int'(sc[j]) - int'(sh);
                if (!st_v[s] && pv[R][K] && sv[j] &&
                    d <= int'(win) && d >= -int'(win)) begin
                    st_v[s]    = 1'b1;
                    st[s].row  = ROW_W'(R);
                    st[s].phi  = pc[R][K];
                    st[s].bend = BEND_W'(d);
                end
            end
        end
    end
endmodule

// File: rtl/stub_finder.sv
module stub_finder
    import stub_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 120,
    parameter int PMAX = 4,
    parameter int SMAX = 8,
    localparam int SLOTS = ROWS * PMAX
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ROWS*COLS-1:0]        pix_hits,
    input  logic [COLS-1:0]             strip_hits,
    input  logic signed [SHIFT_W-1:0]   phi_shift,
    input  logic [WIN_W-1:0]            win,
    input  logic [WIDE_W-1:0]           wide_max,
    output logic [SLOTS-1:0]            stub_valid,
    output logic [SLOTS*STUB_W-1:0]     stub_word,
    output logic [ROWS-1:0]             row_ovf,
    output logic                        strip_ovf
);
    // stage 0: capture frame and its configuration
    logic [ROWS*COLS-1:0]        s0_pix;
    logic [COLS-1:0]             s0_strip;
    logic signed [SHIFT_W-1:0]   s0_sh;
    logic [WIN_W-1:0]            s0_win;
    logic [WIDE_W-1:0]           s0_wide;

    // stage 1: centroid lists
    logic [ROWS-1:0][PMAX-1:0][CENT_W-1:0] pc_d, s1_pc;
    logic [ROWS-1:0][PMAX-1:0]             pv_d, s1_pv;
    logic [ROWS-1:0]                       rovf_d, s1_rovf;
    logic [SMAX-1:0][CENT_W-1:0]           sc_d, s1_sc;
    logic [SMAX-1:0]                       sv_d, s1_sv;
    logic                                  sovf_d, s1_sovf;
    logic signed [SHIFT_W-1:0]             s1_sh;
    logic [WIN_W-1:0]                      s1_win;

    logic [SLOTS-1:0]  st_v_d;
    stub_t [SLOTS-1:0] st_d, st_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        stub_cluster_enc #(.N(COLS), .MAXC(PMAX)) u_row_enc (
            .hits     (s0_pix[r*COLS +: COLS]),
            .wide_max (s0_wide),
            .cent     (pc_d[r]),
            .vld      (pv_d[r]),
            .ovf      (rovf_d[r])
        );
    end

    stub_cluster_enc #(.N(COLS), .MAXC(SMAX)) u_strip_enc (
        .hits     (s0_strip),
        .wide_max (s0_wide),
        .cent     (sc_d),
        .vld      (sv_d),
        .ovf      (sovf_d)
    );

    stub_match #(.ROWS(ROWS), .PMAX(PMAX), .SMAX(SMAX)) u_match (
        .pc   (s1_pc),
        .pv   (s1_pv),
        .sc   (s1_sc),
        .sv   (s1_sv),
        .sh   (s1_sh),
        .win  (s1_win),
        .st_v (st_v_d),
        .st   (st_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_pix <= '0; s0_strip <= '0; s0_sh <= '0; s0_win <= '0; s0_wide <= '0;
            s1_pc <= '0; s1_pv <= '0; s1_rovf <= '0;
            s1_sc <= '0; s1_sv <= '0; s1_sovf <= 1'b0;
            s1_sh <= '0; s1_win <= '0;
            stub_valid <= '0; st_q <= '0; row_ovf <= '0; strip_ovf <= 1'b0;
        end else begin
            s0_pix   <= pix_hits;
            s0_strip <= strip_hits;
            s0_sh    <= phi_shift;
            s0_win   <= win;
            s0_wide  <= wide_max;
            s1_pc    <= pc_d;
            s1_pv    <= pv_d;
            s1_rovf  <= rovf_d;
            s1_sc    <= sc_d;
            s1_sv    <= sv_d;
            s1_sovf  <= sovf_d;
            s1_sh    <= s0_sh;
            s1_win   <= s0_win;
            stub_valid <= st_v_d;
            st_q       <= st_d;
            row_ovf    <= s1_rovf;
            strip_ovf  <= s1_sovf;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_word
        assign stub_word[s*STUB_W +: STUB_W] = st_q[s];

        AST_BEND_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (!stub_valid[s] || bend_in_window(st_q[s].bend, $past(s1_win)))); // R6
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
        AST_ROW_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
            s1_rovf[r] |-> (&s1_pv[r])); // R3
        AST_ROW_PACKED: assert property (@(posedge clk) disable iff (rst)
            ((s1_pv[r] + 1'b1) & s1_pv[r]) == '0); // R3
    end

    for (genvar j = 0; j < SMAX; j++) begin : g_strip_chk
        AST_CENT_RANGE: assert property (@(posedge clk) disable iff (rst)
            s1_sv[j] |-> (int'(s1_sc[j]) <= 2 * (COLS - 1))); // R1
    end

    AST_STRIP_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
        s1_sovf |-> (&s1_sv)); // R4
    AST_STRIP_PACKED: assert property (@(posedge clk) disable iff (rst)
        ((s1_sv + 1'b1) & s1_sv) == '0); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (stub_valid == '0 && row_ovf == '0 && !strip_ovf)); // R9
endmodule

// File: tb/stub_finder_tb_top.sv
`timescale 1ns/1ps
module stub_finder_tb_top;
    localparam int ROWS = 16, COLS = 120, PMAX = 4, SMAX = 8;
    localparam int SLOTS = ROWS * PMAX, SW = 17;

    typedef struct packed {
        logic [SLOTS-1:0]    v;
        logic [SLOTS*SW-1:0] w;
        logic [ROWS-1:0]     ro;
        logic                so;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ROWS*COLS-1:0] pix_hits = '0;
    logic [COLS-1:0] strip_hits = '0;
    logic signed [7:0] phi_shift = '0;
    logic [3:0] win = '0;
    logic [2:0] wide_max = '0;
    logic [SLOTS-1:0] stub_valid;
    logic [SLOTS*SW-1:0] stub_word;
    logic [ROWS-1:0] row_ovf;
    logic strip_ovf;

    int checks = 0, fails = 0;
    bit done = 0;
    exp_t expq[$];
    logic [ROWS*COLS-1:0] vp;
    logic [COLS-1:0] vs;

    always #5 clk = ~clk;

    stub_finder dut_i (
        .clk(clk), .rst(rst), .pix_hits(pix_hits), .strip_hits(strip_hits),
        .phi_shift(phi_shift), .win(win), .wide_max(wide_max),
        .stub_valid(stub_valid), .stub_word(stub_word),
        .row_ovf(row_ovf), .strip_ovf(strip_ovf)
    );

    function automatic void scan(input logic [COLS-1:0] h, input int wide, input int cap,
                                 output int q[$], output bit ov);
        int c;
        q.delete();
        ov = 0;
        c = 0;
        while (c < COLS) begin
            if (h[c]) begin
                int f;
                f = c;
                while (c < COLS && h[c]) c++;
                if (c - f <= wide) begin
                    if (q.size() < cap) q.push_back(f + c - 1);
                    else ov = 1;
                end
            end else begin
                c++;
            end
        end
    endfunction

    function automatic exp_t model(input logic [ROWS*COLS-1:0] p, input logic [COLS-1:0] s,
                                   input int sh, input int w, input int wide);
        exp_t e;
        int sq[$];
        int pq[$];
        bit ov;
        e = '0;
        scan(s, wide, SMAX, sq, ov);
        e.so = ov;
        for (int r = 0; r < ROWS; r++) begin
            scan(p[r*COLS +: COLS], wide, PMAX, pq, ov);
            e.ro[r] = ov;
            for (int k = 0; k < pq.size(); k++) begin
                for (int j = 0; j < sq.size(); j++) begin
                    int d;
                    d = pq[k] - sq[j] - sh;
                    if (d <= w && d >= -w) begin
                        e.v[r*PMAX+k] = 1'b1;
                        e.w[(r*PMAX+k)*SW +: SW] = {4'(r), 8'(pq[k]), 5'(d)};
                        break;
                    end
                end
            end
        end
        return e;
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (stub_valid !== e.v || stub_word !== e.w) begin
            fails++;
            $display("FAIL R6/R7 stubs: valid act=%h exp=%h word act=%h exp=%h",
                     stub_valid, e.v, stub_word, e.w);
        end
        checks++;
        if (row_ovf !== e.ro) begin
            fails++;
            $display("FAIL R3 row_ovf act=%h exp=%h", row_ovf, e.ro);
        end
        checks++;
        if (strip_ovf !== e.so) begin
            fails++;
            $display("FAIL R4 strip_ovf act=%b exp=%b", strip_ovf, e.so);
        end
    endtask

    // one frame per cycle; the result of the frame driven three negedges earlier is checked (R8)
    task automatic apply(input logic [ROWS*COLS-1:0] p, input logic [COLS-1:0] s,
                         input logic [7:0] sh, input int w, input int wide);
        @(negedge clk);
        if (expq.size() == 3) compare(expq.pop_front());
        pix_hits   = p;
        strip_hits = s;
        phi_shift  = sh;
        win        = 4'(w);
        wide_max   = 3'(wide);
        expq.push_back(model(p, s, int'($signed(sh)), w, wide));
    endtask

    function automatic logic [ROWS*COLS-1:0] px(input logic [ROWS*COLS-1:0] p,
                                                input int r, input int c, input int n);
        for (int i = 0; i < n; i++) p[r*COLS + c + i] = 1'b1;
        return p;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: reset with busy inputs keeps outputs clear
        pix_hits = '1; strip_hits = '1; win = 4'd15; wide_max = 3'd7;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (stub_valid !== '0 || stub_word !== '0 || row_ovf !== '0 || strip_ovf !== 1'b0) begin
                fails++;
                $display("FAIL R9 reset outputs act=%h/%h/%b exp=0", stub_valid, row_ovf, strip_ovf);
            end
        end
        pix_hits = '0; strip_hits = '0; win = '0; wide_max = '0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) expq.push_back('0);

        // R1 R6: single two-wide clusters at equal position, bend 0
        vp = px('0, 0, 10, 2); vs = '0; vs[11:10] = '1;
        apply(vp, vs, 8'd0, 4, 3);
        // R2: width 3 kept, width 4 dropped in both layers
        vp = px(px('0, 1, 20, 3), 1, 30, 4); vs = '0; vs[21] = 1'b1; vs[43:40] = '1;
        apply(vp, vs, 8'd0, 4, 3);
        // R2: wide limit 0 drops everything
        apply(vp, vs, 8'd0, 4, 0);
        // R3: six singles in row 5 -> lowest four kept, flag; row 6 wide cluster not counted
        vp = '0;
        for (int i = 0; i < 6; i++) vp = px(vp, 5, 2*i, 1);
        for (int i = 0; i < 4; i++) vp = px(vp, 6, 3*i, 1);
        vp = px(vp, 6, 40, 5);
        vs = '0; vs[6] = 1'b1; vs[10] = 1'b1;
        apply(vp, vs, 8'd0, 0, 3);
        // R4: ten strip singles -> eight kept, flag; ninth centroid gives no stub
        vs = '0;
        for (int i = 0; i < 10; i++) vs[4*i] = 1'b1;
        vp = px(px('0, 3, 32, 1), 4, 28, 1);
        apply(vp, vs, 8'd0, 0, 3);
        // R5: positive and negative phi offset
        vs = '0; vs[50] = 1'b1;
        apply(px('0, 7, 53, 1), vs, 8'd6, 0, 3);
        apply(px('0, 7, 47, 1), vs, 8'hFA, 0, 3);
        // R6: window edges +4, +5, -4, -5
        vp = px(px(px(px('0, 0, 52, 1), 1, 52, 2), 2, 48, 1), 3, 47, 2);
        apply(vp, vs, 8'd0, 4, 3);
        // R7: same strip in every row; two strips qualify -> earliest used
        vs = '0; vs[60] = 1'b1; vs[62] = 1'b1;
        vp = '0;
        for (int r = 0; r < ROWS; r++) vp = px(vp, r, 61, 1);
        apply(vp, vs, 8'd0, 4, 3);
        // R1: clusters at both array edges
        vs = '0; vs[0] = 1'b1; vs[COLS-1] = 1'b1;
        apply(px(px('0, 15, 0, 1), 15, COLS-1, 1), vs, 8'd0, 0, 1);

        // R8: random frames with per-frame configuration, back to back
        for (int n = 0; n < 300; n++) begin
            vp = '0; vs = '0;
            for (int b = 0; b < ROWS*COLS; b++) vp[b] = ($urandom_range(0, 99) < 4);
            for (int b = 0; b < COLS; b++) vs[b] = ($urandom_range(0, 99) < 8);
            apply(vp, vs, 8'($urandom_range(0, 255)), $urandom_range(0, 15),
                  (n % 20 == 0) ? 0 : $urandom_range(1, 7));
        end
        for (int i = 0; i < 3; i++) apply('0, '0, 8'd0, 0, 0);
        @(negedge clk);
        while (expq.size() > 0) begin
            compare(expq.pop_front());
            @(negedge clk);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule